// File: doc/BRIEF.md
# Byte-Lane Static Memory with Per-Lane Error Correction

This block is a clocked model of a 16-bit-wide static memory built as two independent 8-bit lanes. Each lane keeps its byte as a 12-bit single-error-correcting Hamming codeword. Because the check bits cover one byte only, a write to one byte never needs to read back the other byte.

Access is controlled by active-low pins. A chip select gates every access. A write strobe picks between a write cycle and a read cycle. An output enable allows the read data to be driven. Two lane selects pick the low byte and the high byte. Tri-state pins are not used. A registered per-lane drive flag says which byte of the read bus is valid, and a lane that is not driven reads as zero.

On a read, each lane computes its syndrome and repairs a single flipped bit. A per-lane flag marks any lane whose stored codeword was not clean. A test port can XOR a mask into any stored codeword, so the correction logic can be exercised from outside the block.

Top module: `bytelane_ecc_sram`

## Requirements
- R1: The memory holds 2^ADDR_W words of 16 bits. A word written at an address reads back unchanged from that address until it is overwritten.
- R2: Each lane stores a 12-bit codeword. Codeword bit k holds Hamming position k+1. Check bits sit at positions 1, 2, 4 and 8. Data bits 0 to 7 sit, in order, at positions 3, 5, 6, 7, 9, 10, 11 and 12. Each check bit is the even parity of the positions whose index has that check's bit set. As a result, XOR-ing the valid pattern 0x007 into lane 0 flips data bit 0, and XOR-ing 0x888 flips data bit 7, with no error flagged.
- R3: While ce_n is high, no lane is written and, one cycle later, lane_oe is 00, whatever the other controls are.
- R4: With ce_n low, we_n high and oe_n high, lane_oe is 00 one cycle later and the stored contents do not change.
- R5: With ub_n and lb_n both high, no write happens and lane_oe is 00 one cycle later, whatever we_n and oe_n are.
- R6: A read cycle is ce_n low, we_n high and oe_n low. One clock after that cycle, lane_oe[0] is high exactly when lb_n was low (data bits 7:0), and lane_oe[1] is high exactly when ub_n was low (data bits 15:8).
- R7: Any lane whose lane_oe bit is low presents zero on its rdata bits.
- R8: A write cycle is ce_n low and we_n low, and oe_n has no effect on it. Only the lanes whose select is low are written. An unselected lane keeps its old byte, and lane_oe is 00 after a write cycle.
- R9: A single flipped bit at any of the 12 codeword positions of a lane is corrected, so the read returns the byte as written.
- R10: lane_fix[i] is high, in the same cycle as the read data, exactly when lane i is driven and its syndrome is nonzero. It is low on a clean read.
- R11: When inj_en is high, inj_mask is XOR-ed into the codeword at inj_addr of lane inj_lane (0 = low byte, 1 = high byte) at the clock edge. A write to the same lane and address in the same cycle takes priority, and the injection is dropped.
- R12: While rst_n is low, rdata, lane_oe and lane_fix are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes, injections and read registers update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable for read cycles |
| we_n | input | 1 | Active-low write strobe; high selects a read cycle |
| lb_n | input | 1 | Active-low select for data bits 7:0 |
| ub_n | input | 1 | Active-low select for data bits 15:8 |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered, corrected read data; zero in undriven lanes |
| lane_oe | output | 2 | Registered per-lane drive flags (bit 0 low byte, bit 1 high byte) |
| lane_fix | output | 2 | Registered per-lane flag for a nonzero syndrome |
| inj_en | input | 1 | Fault injection strobe |
| inj_lane | input | 1 | Lane to corrupt (0 low, 1 high) |
| inj_addr | input | ADDR_W | Word address to corrupt |
| inj_mask | input | 12 | Bits to flip in the stored codeword |

## Verification
The bench flips each of the 12 codeword positions in each lane in turn. A design with a check bit placed wrongly, or with a syndrome decoded wrongly, would return a damaged byte or set the wrong lane's flag. Injecting whole valid codewords pins the data bit layout: a mapping that is off by one position would raise the error flag or flip the wrong data bit. Single-byte writes with oe_n low, and writes with both selects high, catch enable decoding that writes the unselected lane, drives during a write, or lets oe_n block a write. A write and an injection that hit the same lane and address in one cycle show whether the write really wins, or whether a stale flip leaks into the stored word.

// File: rtl/sram_ecc_pkg.sv
package sram_ecc_pkg;
  localparam int LANE_W = 8;
  localparam int CODE_W = 12;
  localparam int SYN_W  = 4;
  localparam int LANES  = 2;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [LANE_W-1:0] byte_t;
  typedef logic [SYN_W-1:0]  syn_t;

  function automatic logic is_chk_pos(int pos);
    return (pos == 1) || (pos == 2) || (pos == 4) || (pos == 8);
  endfunction

  // Place the data bits at the non-power-of-two positions, then fill the check bits.
  function automatic code_t ham_encode(byte_t d);
    code_t c;
    int    k;
    c = '0;
    k = 0;
    for (int pos = 1; pos <= CODE_W; pos++) begin
      if (!is_chk_pos(pos)) begin
        c[pos-1] = d[k];
        k++;
      end
    end
    for (int b = 0; b < SYN_W; b++) begin
      logic par;
      par = 1'b0;
      for (int pos = 1; pos <= CODE_W; pos++)
        if (((pos >> b) & 1) == 1 && !is_chk_pos(pos)) par ^= c[pos-1];
      c[(1 << b) - 1] = par;
    end
    return c;
  endfunction

  function automatic syn_t ham_syndrome(code_t c);
    syn_t s;
    s = '0;
    for (int pos = 1; pos <= CODE_W; pos++)
      if (c[pos-1]) s ^= SYN_W'(pos);
    return s;
  endfunction

  function automatic byte_t ham_extract(code_t c);
    byte_t d;
    int    k;
    d = '0;
    k = 0;
    for (int pos = 1; pos <= CODE_W; pos++) begin
      if (!is_chk_pos(pos)) begin
        d[k] = c[pos-1];
        k++;
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/lane_store.sv
module lane_store
  import sram_ecc_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  byte_t             wr_byte,
  input  logic              inj_en,
  input  logic [ADDR_W-1:0] inj_addr,
  input  code_t             inj_mask,
  output code_t             rd_code
);
  localparam int DEPTH = 1 << ADDR_W;

  code_t mem [DEPTH];
  code_t wr_code;
  logic  inj_go;

  always_comb begin
    wr_code = ham_encode(wr_byte);
    // A write to the same word in the same cycle overrides the injection.
    inj_go  = inj_en && !(wr_en && (inj_addr == addr));
  end

  always_ff @(posedge clk) begin
    if (wr_en)  mem[addr]     <= wr_code;
    if (inj_go) mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
  end

  assign rd_code = mem[addr];
endmodule

// File: rtl/lane_decode.sv
module lane_decode
  import sram_ecc_pkg::*;
(
  input  code_t code_in,
  output byte_t data_out,
  output logic  err_seen
);
  syn_t  syn;
  code_t fixed;

  always_comb begin
    syn = ham_syndrome(code_in);
    for (int pos = 1; pos <= CODE_W; pos++)
      fixed[pos-1] = code_in[pos-1] ^ (syn == SYN_W'(pos));
    data_out = ham_extract(fixed);
    err_seen = |syn;
  end
endmodule

// File: rtl/bytelane_ecc_sram.sv
module bytelane_ecc_sram
  import sram_ecc_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ce_n,
  input  logic                     oe_n,
  input  logic                     we_n,
  input  logic                     lb_n,
  input  logic                     ub_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [LANES*LANE_W-1:0]  wdata,
  output logic [LANES*LANE_W-1:0]  rdata,
  output logic [LANES-1:0]         lane_oe,
  output logic [LANES-1:0]         lane_fix,
  input  logic                     inj_en,
  input  logic                     inj_lane,
  input  logic [ADDR_W-1:0]        inj_addr,
  input  logic [CODE_W-1:0]        inj_mask
);
  localparam int BUS_W = LANES * LANE_W;

  logic [LANES-1:0] sel_n;
  logic             wr_cyc;
  logic             rd_cyc;
  logic [BUS_W-1:0] dec_data;
  logic [LANES-1:0] dec_err;

  logic [BUS_W-1:0] rdata_d;
  logic [LANES-1:0] oe_d;
  logic [LANES-1:0] fix_d;

  assign sel_n  = {ub_n, lb_n};
  assign wr_cyc = !ce_n && !we_n;
  assign rd_cyc = !ce_n &&  we_n && !oe_n;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    code_t lane_code;
    logic  lane_wr;
    logic  lane_inj;

    assign lane_wr  = wr_cyc && !sel_n[g];
    assign lane_inj = inj_en && (inj_lane == 1'(g));

    lane_store #(.ADDR_W(ADDR_W)) u_store (
      .clk      (clk),
      .wr_en    (lane_wr),
      .addr     (addr),
      .wr_byte  (wdata[g*LANE_W +: LANE_W]),
      .inj_en   (lane_inj),
      .inj_addr (inj_addr),
      .inj_mask (inj_mask),
      .rd_code  (lane_code)
    );

    lane_decode u_dec (
      .code_in  (lane_code),
      .data_out (dec_data[g*LANE_W +: LANE_W]),
      .err_seen (dec_err[g])
    );
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      oe_d[i]                  = rd_cyc && !sel_n[i];
      fix_d[i]                 = oe_d[i] && dec_err[i];
      rdata_d[i*LANE_W +: LANE_W] = oe_d[i] ? dec_data[i*LANE_W +: LANE_W] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      lane_oe  <= '0;
      lane_fix <= '0;
    end else begin
      rdata    <= rdata_d;
      lane_oe  <= oe_d;
      lane_fix <= fix_d;
    end
  end
endmodule

// File: rtl/bytelane_ecc_sram_chk.sv
module bytelane_ecc_sram_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ce_n,
  input logic        oe_n,
  input logic        we_n,
  input logic        lb_n,
  input logic        ub_n,
  input logic [15:0] rdata,
  input logic [1:0]  lane_oe,
  input logic [1:0]  lane_fix
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r3_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(ce_n)) |-> (lane_oe == 2'b00));

  a_r8_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(!ce_n && !we_n)) |-> (lane_oe == 2'b00));

  a_r4_oe_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(oe_n)) |-> (lane_oe == 2'b00));

  a_r6_low_lane_select: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && lane_oe[0]) |-> $past(!lb_n));

  a_r6_high_lane_select: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && lane_oe[1]) |-> $past(!ub_n));

  a_r5_no_select_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(lb_n && ub_n)) |-> (lane_oe == 2'b00));

  a_r7_low_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_oe[0] |-> (rdata[7:0] == 8'h00));

  a_r7_high_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_oe[1] |-> (rdata[15:8] == 8'h00));

  a_r10_fix_needs_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_fix & ~lane_oe) == 2'b00);
endmodule

bind bytelane_ecc_sram bytelane_ecc_sram_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ce_n     (ce_n),
  .oe_n     (oe_n),
  .we_n     (we_n),
  .lb_n     (lb_n),
  .ub_n     (ub_n),
  .rdata    (rdata),
  .lane_oe  (lane_oe),
  .lane_fix (lane_fix)
);

// File: tb/sim_bytelane_ecc_sram.sv
module sim_bytelane_ecc_sram;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW = 11;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, oe_n, we_n, lb_n, ub_n;
  logic [AW-1:0] addr;
  logic [15:0]   wdata;
  logic [15:0]   rdata;
  logic [1:0]    lane_oe, lane_fix;
  logic          inj_en, inj_lane;
  logic [AW-1:0] inj_addr;
  logic [11:0]   inj_mask;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  bytelane_ecc_sram #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .wdata(wdata), .rdata(rdata),
    .lane_oe(lane_oe), .lane_fix(lane_fix), .inj_en(inj_en),
    .inj_lane(inj_lane), .inj_addr(inj_addr), .inj_mask(inj_mask)
  );

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle();
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; lb_n = 1'b1; ub_n = 1'b1;
    addr = '0; wdata = '0; inj_en = 1'b0; inj_lane = 1'b0;
    inj_addr = '0; inj_mask = '0;
  endtask

  // One bus cycle: drive at the falling edge, let the rising edge act, sample just after it.
  task automatic bus(logic c, logic o, logic w, logic l, logic u,
                     logic [AW-1:0] a, logic [15:0] d);
    @(negedge clk);
    idle();
    ce_n = c; oe_n = o; we_n = w; lb_n = l; ub_n = u; addr = a; wdata = d;
    @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [15:0] d, logic l, logic u, logic o);
    bus(1'b0, o, 1'b0, l, u, a, d);
  endtask

  task automatic rd_check(string req, logic [AW-1:0] a, logic l, logic u,
                          logic [15:0] exp_d, logic [1:0] exp_oe, logic [1:0] exp_fix);
    bus(1'b0, 1'b0, 1'b1, l, u, a, 16'h0);
    check(req, rdata, exp_d);
    check(req, {14'h0, lane_oe}, {14'h0, exp_oe});
    check(req, {14'h0, lane_fix}, {14'h0, exp_fix});
  endtask

  task automatic inject(logic lane, logic [AW-1:0] a, logic [11:0] m);
    @(negedge clk);
    idle();
    inj_en = 1'b1; inj_lane = lane; inj_addr = a; inj_mask = m;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R12 rdata", rdata, 16'h0);
    check("R12 lane_oe", {14'h0, lane_oe}, 16'h0);
    check("R12 lane_fix", {14'h0, lane_fix}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_words();
    wr(11'd0,    16'h1234, 1'b0, 1'b0, 1'b1);
    wr(11'd1,    16'hFFFF, 1'b0, 1'b0, 1'b1);
    wr(11'd2047, 16'h8001, 1'b0, 1'b0, 1'b1);
    wr(11'd1024, 16'h0000, 1'b0, 1'b0, 1'b1);
    rd_check("R1 addr0",    11'd0,    1'b0, 1'b0, 16'h1234, 2'b11, 2'b00);
    rd_check("R1 addr1",    11'd1,    1'b0, 1'b0, 16'hFFFF, 2'b11, 2'b00);
    rd_check("R1 addr2047", 11'd2047, 1'b0, 1'b0, 16'h8001, 2'b11, 2'b00);
    rd_check("R1 addr1024", 11'd1024, 1'b0, 1'b0, 16'h0000, 2'b11, 2'b00);
  endtask

  task automatic t_byte_lanes();
    wr(11'd5, 16'hBEEF, 1'b0, 1'b0, 1'b1);
    // low-byte write with oe_n low: oe_n must not block it, upper byte kept
    wr(11'd5, 16'h77A5, 1'b0, 1'b1, 1'b0);
    check("R8 no drive after write", {14'h0, lane_oe}, 16'h0);
    rd_check("R8 low only", 11'd5, 1'b0, 1'b0, 16'hBEA5, 2'b11, 2'b00);
    wr(11'd5, 16'h3C11, 1'b1, 1'b0, 1'b1);
    rd_check("R8 high only", 11'd5, 1'b0, 1'b0, 16'h3CA5, 2'b11, 2'b00);
    rd_check("R6 R7 low lane read",  11'd5, 1'b0, 1'b1, 16'h00A5, 2'b01, 2'b00);
    rd_check("R6 R7 high lane read", 11'd5, 1'b1, 1'b0, 16'h3C00, 2'b10, 2'b00);
  endtask

  task automatic t_quiet();
    wr(11'd9, 16'h5AA5, 1'b0, 1'b0, 1'b1);
    // deselected write attempt
    bus(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 11'd9, 16'h1111);
    check("R3 no drive", {14'h0, lane_oe}, 16'h0);
    // deselected read attempt
    bus(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 11'd9, 16'h0);
    check("R3 read blocked", {14'h0, lane_oe}, 16'h0);
    check("R3 R7 rdata zero", rdata, 16'h0);
    rd_check("R3 contents kept", 11'd9, 1'b0, 1'b0, 16'h5AA5, 2'b11, 2'b00);
    // output disabled
    bus(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 11'd9, 16'h2222);
    check("R4 no drive", {14'h0, lane_oe}, 16'h0);
    check("R4 R7 rdata zero", rdata, 16'h0);
    rd_check("R4 contents kept", 11'd9, 1'b0, 1'b0, 16'h5AA5, 2'b11, 2'b00);
    // both selects high, write strobe low
    bus(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 11'd9, 16'h3333);
    check("R5 no drive write", {14'h0, lane_oe}, 16'h0);
    bus(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 11'd9, 16'h0);
    check("R5 no drive read", {14'h0, lane_oe}, 16'h0);
    rd_check("R5 contents kept", 11'd9, 1'b0, 1'b0, 16'h5AA5, 2'b11, 2'b00);
  endtask

  task automatic t_single_flips();
    for (int lane = 0; lane < 2; lane++) begin
      for (int pos = 0; pos < 12; pos++) begin
        wr(11'd300, 16'hC35A, 1'b0, 1'b0, 1'b1);
        inject(lane[0], 11'd300, 12'(1 << pos));
        rd_check("R9 R10 R11 single flip", 11'd300, 1'b0, 1'b0, 16'hC35A,
                 2'b11, 2'(1 << lane));
      end
    end
  endtask

  task automatic t_layout();
    wr(11'd40, 16'h0F0F, 1'b0, 1'b0, 1'b1);
    inject(1'b0, 11'd40, 12'h007);
    rd_check("R2 data bit0 pattern", 11'd40, 1'b0, 1'b0, 16'h0F0E, 2'b11, 2'b00);
    inject(1'b1, 11'd40, 12'h888);
    rd_check("R2 data bit7 pattern", 11'd40, 1'b0, 1'b0, 16'h8F0E, 2'b11, 2'b00);
  endtask

  task automatic t_collision();
    wr(11'd77, 16'h1111, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    idle();
    ce_n = 1'b0; we_n = 1'b0; lb_n = 1'b0; ub_n = 1'b1;
    addr = 11'd77; wdata = 16'h0055;
    inj_en = 1'b1; inj_lane = 1'b0; inj_addr = 11'd77; inj_mask = 12'h004;
    @(posedge clk);
    #1;
    rd_check("R11 write beats inject", 11'd77, 1'b0, 1'b0, 16'h1155, 2'b11, 2'b00);
    // injection elsewhere in the same cycle as a write still lands
    @(negedge clk);
    idle();
    ce_n = 1'b0; we_n = 1'b0; lb_n = 1'b0; ub_n = 1'b0;
    addr = 11'd78; wdata = 16'h2222;
    inj_en = 1'b1; inj_lane = 1'b1; inj_addr = 11'd77; inj_mask = 12'h010;
    @(posedge clk);
    #1;
    rd_check("R11 inject other addr", 11'd77, 1'b0, 1'b0, 16'h1155, 2'b11, 2'b10);
    rd_check("R1 R11 write other addr", 11'd78, 1'b0, 1'b0, 16'h2222, 2'b11, 2'b00);
  endtask

  initial begin
    t_reset();
    t_words();
    t_byte_lanes();
    t_quiet();
    t_single_flips();
    t_layout();
    t_collision();
    @(negedge clk);
    idle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule